// File: doc/BRIEF.md
# Bus Error Capture Bank

This block records the context of the first failed bus transaction and presents it to software through three 32-bit registers on a small memory-mapped slave port. When the error strobe pulses, the block stores the failing address, the data word, the byte enables, the bus command and a flag that identifies which side raised the error. The byte enables and the command are packed into the upper byte of the status word. A second one-cycle strobe reports that a retry counter ran out.

Software reads the captured context, then clears the pending and retry-expired flags by writing ones to them. Two level outputs follow those flags, so a controller can hold off new traffic until software has dealt with the error. While an error is pending, later errors do not overwrite the stored context. A single enable bit in the status word gates capture. The whole block runs on one clock and has an asynchronous active-low reset.

Top module: `errcap_bank`

## Requirements
- R1: After reset the status word (offset 0x0) reads 0x0000_0001, with the enable bit at bit 0 set. The address word (offset 0x4) and the data word (offset 0x8) read 0x0000_0000, and both level outputs are low.
- R2: An error strobe seen while enabled loads the address and data words from the strobe inputs. It puts the byte enables in status bits [31:28] and the command in bits [27:24], sets pending (bit 8) and copies the source flag into bit 9. For example, enables 0xF, command 0xF and source 1 give 0xFF00_0301.
- R3: `err_pending` follows status bit 8. It is low while the strobe is being presented and high in the cycle after the clock edge that captured it.
- R4: A write whose byte enable 1 is set and whose data bit 8 is 1 clears pending and drops `err_pending`. The enable bit, the source bit and the captured fields are kept, so a byte-1 write of 0x0000_0100 after the R2 example leaves 0xFF00_0201.
- R5: A retry-expired strobe sets status bit 10 and raises `rty_expired`. With the R2 capture still held, the status word reads 0xFF00_0601.
- R6: A full-word write of 0xFFFF_FFFF to the status word clears bits 8 and 10 and both outputs. The enable bit, the source bit and the byte-enable and command fields stay as they were.
- R7: The enable bit is written through byte enable 0 from data bit 0. While it is 0, error strobes change nothing.
- R8: While pending is set, a new error strobe leaves the address, data, source and field contents unchanged, so the first error is kept until it is cleared.
- R9: Status bits [7:1] and [23:11], and every offset other than 0x0, 0x4 and 0x8, read as zero. Writes to them, and to the address and data words, have no effect.
- R10: Each one-cycle request gets `s_ack` high in the next cycle, and `s_rdata` is valid with it. Back-to-back requests get back-to-back acknowledges, and the acknowledge is low when there is no request.
- R11: When a status write that clears a flag lands in the same cycle as a strobe that sets it, the set wins. An error strobe in that cycle is captured into the freshly freed registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| err_stb | input | 1 | One-cycle strobe: a bus error occurred |
| err_src | input | 1 | Source flag of the error, stored in status bit 9 |
| err_addr | input | 32 | Address of the failed transaction |
| err_data | input | 32 | Data of the failed transaction |
| err_be | input | 4 | Byte enables of the failed transaction |
| err_cmd | input | 4 | Bus command of the failed transaction |
| rty_stb | input | 1 | One-cycle strobe: retry limit expired |
| s_req | input | 1 | Slave request, one cycle per access |
| s_we | input | 1 | 1 for write, 0 for read |
| s_ofs | input | 4 | Byte offset of the access |
| s_be | input | 4 | Byte enables of the access |
| s_wdata | input | 32 | Write data |
| s_ack | output | 1 | Acknowledge, one cycle after each request |
| s_rdata | output | 32 | Read data, valid with `s_ack` |
| err_pending | output | 1 | Level mirror of the pending flag |
| rty_expired | output | 1 | Level mirror of the retry-expired flag |

## Verification
Software clearing a flag and hardware setting that same flag can land on the same clock edge. The bench provokes this by presenting a full-word status write of all ones in the same cycle as an error strobe carrying new context and a retry strobe. The result is judged at the ports: both level outputs must still be high after that edge, and a later read must return the new byte enables, command and source along with the new address. That shows the capture went into the registers the clear had just freed.

// File: rtl/errcap_pkg.sv
package errcap_pkg;
   // Status word layout. Software decodes these positions.
   localparam int unsigned BIT_EN   = 0;
   localparam int unsigned BIT_PEND = 8;
   localparam int unsigned BIT_SRC  = 9;
   localparam int unsigned BIT_REXP = 10;
   localparam int unsigned LSB_CMD  = 24;
   localparam int unsigned LSB_BE   = 28;

   // Word indices on the slave port (byte offset / 4).
   localparam int unsigned WORD_STAT = 0;
   localparam int unsigned WORD_ADDR = 1;
   localparam int unsigned WORD_DATA = 2;

   typedef struct packed {
      logic en;
      logic pend;
      logic src;
      logic rexp;
   } flags_t;
endpackage

// File: rtl/errcap_hold.sv
module errcap_hold #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         cap,
   input  logic [W-1:0] din,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= '0;
      else if (cap) q <= din;
   end

   // R8: contents only move on a capture granted by the status logic
   a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !cap |=> $stable(q));
endmodule

// File: rtl/errcap_status.sv
module errcap_status
   import errcap_pkg::*;
#(
   parameter int unsigned BE_W         = 4,
   parameter int unsigned CMD_W        = 4,
   parameter int unsigned BUS_W        = 32,
   parameter bit          EN_RESET     = 1'b1,
   parameter bit          RTY_NEEDS_EN = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             err_stb,
   input  logic             err_src,
   input  logic [BE_W-1:0]  err_be,
   input  logic [CMD_W-1:0] err_cmd,
   input  logic             rty_stb,
   input  logic             en_wr,
   input  logic             en_val,
   input  logic             clr_pend,
   input  logic             clr_rexp,
   output logic             cap,
   output logic [BUS_W-1:0] status_word
);
   flags_t           fl_q;
   logic [BE_W-1:0]  be_q;
   logic [CMD_W-1:0] cmd_q;
   logic             rty_set;

   // A clear arriving with a strobe frees the registers for that strobe (R11).
   assign cap = err_stb & fl_q.en & (~fl_q.pend | clr_pend);

   generate
      if (RTY_NEEDS_EN) begin : g_rty_gated
         assign rty_set = rty_stb & fl_q.en;
      end else begin : g_rty_free
         assign rty_set = rty_stb;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fl_q.en   <= EN_RESET;
         fl_q.pend <= 1'b0;
         fl_q.src  <= 1'b0;
         fl_q.rexp <= 1'b0;
         be_q      <= '0;
         cmd_q     <= '0;
      end else begin
         if (en_wr) fl_q.en <= en_val;
         if (cap) begin
            fl_q.pend <= 1'b1;
            fl_q.src  <= err_src;
            be_q      <= err_be;
            cmd_q     <= err_cmd;
         end else if (clr_pend) begin
            fl_q.pend <= 1'b0;
         end
         if (rty_set)       fl_q.rexp <= 1'b1;
         else if (clr_rexp) fl_q.rexp <= 1'b0;
      end
   end

   always_comb begin
      status_word                           = '0;
      status_word[BIT_EN]                   = fl_q.en;
      status_word[BIT_PEND]                 = fl_q.pend;
      status_word[BIT_SRC]                  = fl_q.src;
      status_word[BIT_REXP]                 = fl_q.rexp;
      status_word[LSB_CMD +: CMD_W]         = cmd_q;
      status_word[LSB_BE +: BE_W]           = be_q;
   end

   // R2 / R11: a granted capture always leaves pending set
   a_r2_cap_sets_pend: assert property (@(posedge clk) disable iff (!rst_n)
      cap |=> status_word[BIT_PEND]);
   // R4: a clear without a competing capture drops pending
   a_r4_clear_pend: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_pend && !cap) |=> !status_word[BIT_PEND]);
   // R5 / R11: a retry strobe wins over a same-cycle clear
   a_r5_rty_sets: assert property (@(posedge clk) disable iff (!rst_n)
      rty_set |=> status_word[BIT_REXP]);
   // R7: no new error can be recorded while capture is disabled
   a_r7_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !fl_q.en |=> !$rose(status_word[BIT_PEND]));
endmodule

// File: rtl/errcap_regif.sv
module errcap_regif
   import errcap_pkg::*;
#(
   parameter int unsigned BUS_W = 32,
   parameter int unsigned OFS_W = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               s_req,
   input  logic               s_we,
   input  logic [OFS_W-1:0]   s_ofs,
   input  logic [BUS_W/8-1:0] s_be,
   input  logic [BUS_W-1:0]   s_wdata,
   input  logic [BUS_W-1:0]   status_word,
   input  logic [BUS_W-1:0]   addr_word,
   input  logic [BUS_W-1:0]   data_word,
   output logic               en_wr,
   output logic               en_val,
   output logic               clr_pend,
   output logic               clr_rexp,
   output logic               s_ack,
   output logic [BUS_W-1:0]   s_rdata
);
   localparam int unsigned WIDX_W = OFS_W - 2;

   logic [WIDX_W-1:0] widx;
   logic              hit_stat;
   logic [BUS_W-1:0]  rd_mux;
   logic              unused_bits;

   assign widx     = s_ofs[OFS_W-1:2];
   assign hit_stat = s_req & s_we & (widx == WIDX_W'(WORD_STAT));
   assign en_wr    = hit_stat & s_be[0];
   assign en_val   = s_wdata[BIT_EN];
   assign clr_pend = hit_stat & s_be[1] & s_wdata[BIT_PEND];
   assign clr_rexp = hit_stat & s_be[1] & s_wdata[BIT_REXP];

   assign unused_bits = ^{s_ofs[1:0], s_be[BUS_W/8-1:2],
                          s_wdata[BUS_W-1:BIT_REXP+1], s_wdata[BIT_SRC],
                          s_wdata[BIT_PEND-1:BIT_EN+1]};

   always_comb begin
      case (widx)
         WIDX_W'(WORD_STAT): rd_mux = status_word;
         WIDX_W'(WORD_ADDR): rd_mux = addr_word;
         WIDX_W'(WORD_DATA): rd_mux = data_word;
         default:            rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s_ack   <= 1'b0;
         s_rdata <= '0;
      end else begin
         s_ack   <= s_req;
         s_rdata <= (s_req && !s_we) ? rd_mux : '0;
      end
   end

   // R10: exactly one acknowledge per request cycle
   a_r10_ack_follows: assert property (@(posedge clk) disable iff (!rst_n)
      s_req |=> s_ack);
   a_r10_no_spurious_ack: assert property (@(posedge clk) disable iff (!rst_n)
      !s_req |=> !s_ack);
   // R9: reads of unmapped word slots return zero
   a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (s_req && !s_we && widx > WIDX_W'(WORD_DATA)) |=> (s_rdata == '0));
endmodule

// File: rtl/errcap_bank.sv
module errcap_bank
   import errcap_pkg::*;
#(
   parameter int unsigned BUS_W        = 32,
   parameter int unsigned BE_W         = 4,
   parameter int unsigned CMD_W        = 4,
   parameter int unsigned OFS_W        = 4,
   parameter bit          EN_RESET     = 1'b1,
   parameter bit          RTY_NEEDS_EN = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               err_stb,
   input  logic               err_src,
   input  logic [BUS_W-1:0]   err_addr,
   input  logic [BUS_W-1:0]   err_data,
   input  logic [BE_W-1:0]    err_be,
   input  logic [CMD_W-1:0]   err_cmd,
   input  logic               rty_stb,
   input  logic               s_req,
   input  logic               s_we,
   input  logic [OFS_W-1:0]   s_ofs,
   input  logic [BUS_W/8-1:0] s_be,
   input  logic [BUS_W-1:0]   s_wdata,
   output logic               s_ack,
   output logic [BUS_W-1:0]   s_rdata,
   output logic               err_pending,
   output logic               rty_expired
);
   // Elaboration checks: the packed status layout is fixed.
   generate
      if (BUS_W != 32)        begin : g_chk_bus $error("errcap_bank: BUS_W must be 32"); end
      if (BE_W != BUS_W / 8)  begin : g_chk_be  $error("errcap_bank: BE_W must be BUS_W/8"); end
      if (CMD_W != 4)         begin : g_chk_cmd $error("errcap_bank: CMD_W must be 4"); end
      if (OFS_W < 4)          begin : g_chk_ofs $error("errcap_bank: OFS_W must be at least 4"); end
   endgenerate

   logic             cap;
   logic             en_wr, en_val, clr_pend, clr_rexp;
   logic [BUS_W-1:0] status_word, addr_word, data_word;

   errcap_status #(
      .BE_W(BE_W), .CMD_W(CMD_W), .BUS_W(BUS_W),
      .EN_RESET(EN_RESET), .RTY_NEEDS_EN(RTY_NEEDS_EN)
   ) u_status (
      .clk(clk), .rst_n(rst_n),
      .err_stb(err_stb), .err_src(err_src), .err_be(err_be), .err_cmd(err_cmd),
      .rty_stb(rty_stb),
      .en_wr(en_wr), .en_val(en_val), .clr_pend(clr_pend), .clr_rexp(clr_rexp),
      .cap(cap), .status_word(status_word)
   );

   errcap_hold #(.W(BUS_W)) u_hold_addr (
      .clk(clk), .rst_n(rst_n), .cap(cap), .din(err_addr), .q(addr_word)
   );

   errcap_hold #(.W(BUS_W)) u_hold_data (
      .clk(clk), .rst_n(rst_n), .cap(cap), .din(err_data), .q(data_word)
   );

   errcap_regif #(.BUS_W(BUS_W), .OFS_W(OFS_W)) u_regif (
      .clk(clk), .rst_n(rst_n),
      .s_req(s_req), .s_we(s_we), .s_ofs(s_ofs), .s_be(s_be), .s_wdata(s_wdata),
      .status_word(status_word), .addr_word(addr_word), .data_word(data_word),
      .en_wr(en_wr), .en_val(en_val), .clr_pend(clr_pend), .clr_rexp(clr_rexp),
      .s_ack(s_ack), .s_rdata(s_rdata)
   );

   assign err_pending = status_word[BIT_PEND];
   assign rty_expired = status_word[BIT_REXP];

   // R3: the level output rises only on the edge after an error strobe
   a_r3_pend_rise_after_stb: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_pending) |-> $past(err_stb));
endmodule

// File: tb/errcap_bank_tb.sv
module errcap_bank_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        err_stb = 1'b0, err_src = 1'b0, rty_stb = 1'b0;
   logic [31:0] err_addr = '0, err_data = '0;
   logic [3:0]  err_be = '0, err_cmd = '0;
   logic        s_req = 1'b0, s_we = 1'b0;
   logic [3:0]  s_ofs = '0, s_be = '0;
   logic [31:0] s_wdata = '0;
   logic        s_ack;
   logic [31:0] s_rdata;
   logic        err_pending, rty_expired;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   errcap_bank u_dut (
      .clk(clk), .rst_n(rst_n),
      .err_stb(err_stb), .err_src(err_src), .err_addr(err_addr), .err_data(err_data),
      .err_be(err_be), .err_cmd(err_cmd), .rty_stb(rty_stb),
      .s_req(s_req), .s_we(s_we), .s_ofs(s_ofs), .s_be(s_be), .s_wdata(s_wdata),
      .s_ack(s_ack), .s_rdata(s_rdata),
      .err_pending(err_pending), .rty_expired(rty_expired)
   );

   // Vector: kind[78:77] ofs/cmd[76:73] be[72:69] w[68:37] x[36:5] src[4] req[3:0]
   // kind 0 = read and compare x, 1 = write w, 2 = error strobe (addr w, data x), 3 = retry strobe
   localparam int NV = 31;
   localparam logic [78:0] TBL [NV] = '{
      {2'd0, 4'h0, 4'h0, 32'h0,         32'h0000_0001, 1'b0, 4'd1},  // R1
      {2'd0, 4'h4, 4'h0, 32'h0,         32'h0000_0000, 1'b0, 4'd1},  // R1
      {2'd0, 4'h8, 4'h0, 32'h0,         32'h0000_0000, 1'b0, 4'd1},  // R1
      {2'd2, 4'hF, 4'hF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 4'd2},  // R2
      {2'd0, 4'h0, 4'h0, 32'h0,         32'hFF00_0301, 1'b0, 4'd2},  // R2
      {2'd0, 4'h4, 4'h0, 32'h0,         32'hFFFF_FFFF, 1'b0, 4'd2},  // R2
      {2'd0, 4'h8, 4'h0, 32'h0,         32'hFFFF_FFFF, 1'b0, 4'd2},  // R2
      {2'd2, 4'h1, 4'h1, 32'h0000_1234, 32'h0000_5678, 1'b0, 4'd8},  // R8
      {2'd0, 4'h0, 4'h0, 32'h0,         32'hFF00_0301, 1'b0, 4'd8},  // R8
      {2'd0, 4'h4, 4'h0, 32'h0,         32'hFFFF_FFFF, 1'b0, 4'd8},  // R8
      {2'd1, 4'h0, 4'h2, 32'h0000_0100, 32'h0,         1'b0, 4'd4},  // R4
      {2'd0, 4'h0, 4'h0, 32'h0,         32'hFF00_0201, 1'b0, 4'd4},  // R4
      {2'd3, 4'h0, 4'h0, 32'h0,         32'h0,         1'b0, 4'd5},  // R5
      {2'd0, 4'h0, 4'h0, 32'h0,         32'hFF00_0601, 1'b0, 4'd5},  // R5
      {2'd1, 4'h0, 4'hF, 32'hFFFF_FFFF, 32'h0,         1'b0, 4'd6},  // R6
      {2'd0, 4'h0, 4'h0, 32'h0,         32'hFF00_0201, 1'b0, 4'd6},  // R6
      {2'd1, 4'h4, 4'hF, 32'h0000_0000, 32'h0,         1'b0, 4'd9},  // R9
      {2'd0, 4'h4, 4'h0, 32'h0,         32'hFFFF_FFFF, 1'b0, 4'd9},  // R9
      {2'd0, 4'hC, 4'h0, 32'h0,         32'h0000_0000, 1'b0, 4'd9},  // R9
      {2'd1, 4'hC, 4'hF, 32'hFFFF_FFFF, 32'h0,         1'b0, 4'd9},  // R9
      {2'd0, 4'hC, 4'h0, 32'h0,         32'h0000_0000, 1'b0, 4'd9},  // R9
      {2'd1, 4'h0, 4'h1, 32'h0000_0000, 32'h0,         1'b0, 4'd7},  // R7
      {2'd0, 4'h0, 4'h0, 32'h0,         32'hFF00_0200, 1'b0, 4'd7},  // R7
      {2'd2, 4'h2, 4'h4, 32'h0000_0005, 32'h0000_0006, 1'b0, 4'd7},  // R7
      {2'd0, 4'h0, 4'h0, 32'h0,         32'hFF00_0200, 1'b0, 4'd7},  // R7
      {2'd0, 4'h4, 4'h0, 32'h0,         32'hFFFF_FFFF, 1'b0, 4'd7},  // R7
      {2'd1, 4'h0, 4'h1, 32'h0000_0001, 32'h0,         1'b0, 4'd7},  // R7
      {2'd2, 4'h6, 4'h3, 32'hA5A5_0000, 32'h0000_5A5A, 1'b0, 4'd2},  // R2
      {2'd0, 4'h0, 4'h0, 32'h0,         32'h3600_0101, 1'b0, 4'd2},  // R2
      {2'd0, 4'h4, 4'h0, 32'h0,         32'hA5A5_0000, 1'b0, 4'd2},  // R2
      {2'd0, 4'h8, 4'h0, 32'h0,         32'h0000_5A5A, 1'b0, 4'd2}   // R2
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      end
   endtask

   // Called at a negedge; returns at the negedge where the ack is sampled.
   task automatic bus(input logic we, input logic [3:0] ofs, input logic [3:0] be,
                      input logic [31:0] wd, output logic [31:0] rd);
      s_req = 1'b1; s_we = we; s_ofs = ofs; s_be = be; s_wdata = wd;
      @(negedge clk);
      s_req = 1'b0; s_we = 1'b0; s_be = '0; s_wdata = '0;
      chk("R10 ack", {31'd0, s_ack}, 32'd1);
      rd = s_rdata;
   endtask

   task automatic err_pulse(input logic [31:0] a, input logic [31:0] d,
                            input logic [3:0] be, input logic [3:0] cmd, input logic src);
      err_stb = 1'b1; err_addr = a; err_data = d; err_be = be; err_cmd = cmd; err_src = src;
      @(negedge clk);
      err_stb = 1'b0; err_addr = '0; err_data = '0; err_be = '0; err_cmd = '0; err_src = 1'b0;
   endtask

   task automatic rty_pulse();
      rty_stb = 1'b1;
      @(negedge clk);
      rty_stb = 1'b0;
   endtask

   // Watchdog
   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
   end

   initial begin
      logic [31:0] rd;
      repeat (3) @(negedge clk);
      // R1: reset state at the ports
      chk("R1 pending", {31'd0, err_pending}, 32'd0);
      chk("R1 retry",   {31'd0, rty_expired}, 32'd0);
      chk("R1 ack",     {31'd0, s_ack},       32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         logic [78:0] v;
         string tag;
         v = TBL[i];
         tag = $sformatf("R%0d vec%0d", v[3:0], i);
         case (v[78:77])
            2'd0: begin bus(1'b0, v[76:73], 4'hF, 32'h0, rd); chk(tag, rd, v[36:5]); end
            2'd1: bus(1'b1, v[76:73], v[72:69], v[68:37], rd);
            2'd2: err_pulse(v[68:37], v[36:5], v[72:69], v[76:73], v[4]);
            default: rty_pulse();
         endcase
      end

      // R3: output mirrors pending with one clock of latency
      chk("R3 pending held", {31'd0, err_pending}, 32'd1);
      bus(1'b1, 4'h0, 4'h2, 32'h0000_0100, rd);
      chk("R4 pending cleared", {31'd0, err_pending}, 32'd0);
      err_stb = 1'b1; err_addr = 32'h1111_0000; err_data = 32'h2222_0000;
      err_be = 4'h5; err_cmd = 4'h7; err_src = 1'b0;
      #1;
      chk("R3 low before edge", {31'd0, err_pending}, 32'd0);
      @(negedge clk);
      err_stb = 1'b0;
      chk("R3 high after edge", {31'd0, err_pending}, 32'd1);

      // R11: clear and set collide in one cycle
      rty_pulse();
      chk("R5 retry out", {31'd0, rty_expired}, 32'd1);
      s_req = 1'b1; s_we = 1'b1; s_ofs = 4'h0; s_be = 4'hF; s_wdata = 32'hFFFF_FFFF;
      err_stb = 1'b1; err_addr = 32'hCAFE_0001; err_data = 32'h0BAD_0002;
      err_be = 4'h9; err_cmd = 4'hC; err_src = 1'b1; rty_stb = 1'b1;
      @(negedge clk);
      s_req = 1'b0; s_we = 1'b0; s_be = '0; s_wdata = '0;
      err_stb = 1'b0; rty_stb = 1'b0; err_src = 1'b0;
      chk("R11 pending kept", {31'd0, err_pending}, 32'd1);
      chk("R11 retry kept",   {31'd0, rty_expired}, 32'd1);
      bus(1'b0, 4'h0, 4'hF, 32'h0, rd);
      chk("R11 status", rd, 32'h9C00_0701);
      bus(1'b0, 4'h4, 4'hF, 32'h0, rd);
      chk("R11 address", rd, 32'hCAFE_0001);

      // R6: full clear drops both outputs
      bus(1'b1, 4'h0, 4'hF, 32'hFFFF_FFFF, rd);
      chk("R6 pending out", {31'd0, err_pending}, 32'd0);
      chk("R6 retry out",   {31'd0, rty_expired}, 32'd0);

      // R10: back-to-back requests, then idle
      s_req = 1'b1; s_we = 1'b0; s_ofs = 4'h8;
      @(negedge clk);
      chk("R10 first ack", {31'd0, s_ack}, 32'd1);
      s_ofs = 4'h4;
      @(negedge clk);
      s_req = 1'b0;
      chk("R10 second ack", {31'd0, s_ack}, 32'd1);
      chk("R10 second data", s_rdata, 32'hCAFE_0001);
      @(negedge clk);
      chk("R10 idle ack", {31'd0, s_ack}, 32'd0);

      summary();
      $finish;
   end
endmodule